// File: doc/BRIEF.md
# Interprocessor Mailbox with Per-User Interrupts

This block lets several processors on one chip pass 32-bit words to each other. It holds a number of small hardware message queues. Any processor pushes a word by writing a queue's message port, and the receiving processor pops it by reading the same port. Each queue also has a full flag and an unread count that software can poll.

Interrupt delivery is organised around users, and each user is one interrupt destination with its own output pin. Every queue produces two events. A new-message event fires when a word is accepted. A not-full event fires when a pop frees space in a queue that was full. Both events are latched in every user's status register, and each user's enable register picks which of those latched events drive its pin.

A build-time parameter selects one of two interrupt register layouts. The legacy layout has one plain read/write enable register per user. The split layout has separate enable-set and enable-clear registers. The register bus is a simple single-cycle select/write interface, and read data appears on the cycle after the access.

Top module: `mbox_unit`

## Requirements
- R1: Byte offset 0x000 reads the REVISION parameter value, and a write to it changes nothing.
- R2: Writing offset 0x040+4*m pushes the word into queue m, and reading that offset returns and removes the oldest word, so order is first in, first out. Each queue holds DEPTH words (default 4).
- R3: A write to a full queue is discarded. Its count stays at DEPTH, it raises no event, and the discarded word is never read back.
- R4: A read of an empty queue's message port returns 0 and leaves the count and every status register unchanged.
- R5: Offset 0x080+4*m reads 1 while queue m holds DEPTH words and 0 otherwise.
- R6: Offset 0x0C0+4*m reads the number of unread words in queue m.
- R7: An accepted push into queue m sets bit 2*m (new message) in the status register of every user.
- R8: A pop that takes queue m from full to not full sets bit 2*m+1 (not full) in every user's status register.
- R9: Writing a status register clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R10: With LEGACY=0, user u has status at 0x104+0x10*u, enable-set at 0x108+0x10*u and enable-clear at 0x10C+0x10*u. Writing 1s to enable-set sets enable bits, writing 1s to enable-clear clears them, and reading either register returns the current enables.
- R11: With LEGACY=1, user u has status at 0x100+8*u and a plain read/write enable register at 0x104+8*u.
- R12: irqOut[u] is high exactly when user u's status AND its enable is nonzero.
- R13: After reset, every queue is empty, all status and enable bits are 0 and all interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busSel | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read |
| irqOut | output | NUM_USERS | One interrupt line per user |

## Verification
The not-full event is the hardest case to reach, because it needs a queue filled to exactly its depth and then a single pop. The same fill also sets up the discarded-write case, so the stimulus pushes one word past the depth, checks that the count does not grow, and then drains the queue to confirm that the discarded word never appears. A behavioural model built on bench queues runs alongside two instances, one per register layout, and every read value and interrupt pin is compared with it on each cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [3:0] {
    OP_NONE,
    OP_PUSH,
    OP_POP,
    OP_STS_CLR,
    OP_EN_SET,
    OP_EN_CLR,
    OP_EN_WR,
    OP_RD_REV,
    OP_RD_FULL,
    OP_RD_CNT,
    OP_RD_STS,
    OP_RD_EN
  } mbox_op_e;

  typedef struct packed {
    mbox_op_e   op;
    logic [7:0] idx;
  } mbox_cmd_t;
endpackage

// File: rtl/mbox_queue.sv
module mbox_queue #(
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic [DW-1:0] head
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && (count != '0);
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int          NUM_QUEUES = 4,
  parameter int          NUM_USERS  = 3,
  parameter int          DEPTH      = 4,
  parameter int          ADDR_W     = 10,
  parameter bit          LEGACY     = 1'b0,
  parameter logic [31:0] REVISION   = 32'h0001_0200,
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int EW       = 2 * NUM_QUEUES,
  localparam int STS_BASE = LEGACY ? 32'h100 : 32'h104,
  localparam int USR_STEP = LEGACY ? 8 : 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           busSel,
  input  logic                           busWrite,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [NUM_QUEUES-1:0][CW-1:0]  qCount,
  input  logic [NUM_QUEUES-1:0]          qFull,
  input  logic [NUM_QUEUES-1:0][31:0]    qHead,
  input  logic [NUM_USERS-1:0][EW-1:0]   stsAll,
  input  logic [NUM_USERS-1:0][EW-1:0]   enAll,
  output mbox_cmd_t                      cmd,
  output logic [31:0]                    busRdata
);
  int addr;
  assign addr = int'(32'(busAddr));

  always_comb begin
    cmd.op  = OP_NONE;
    cmd.idx = '0;
    if (busSel) begin
      if (addr == 0) cmd.op = busWrite ? OP_NONE : OP_RD_REV;
      for (int m = 0; m < NUM_QUEUES; m++) begin
        if (addr == 32'h040 + 4 * m) begin
          cmd.op  = busWrite ? OP_PUSH : OP_POP;
          cmd.idx = 8'(m);
        end
        if (addr == 32'h080 + 4 * m) begin
          cmd.op  = busWrite ? OP_NONE : OP_RD_FULL;
          cmd.idx = 8'(m);
        end
        if (addr == 32'h0C0 + 4 * m) begin
          cmd.op  = busWrite ? OP_NONE : OP_RD_CNT;
          cmd.idx = 8'(m);
        end
      end
      for (int u = 0; u < NUM_USERS; u++) begin
        if (addr == STS_BASE + USR_STEP * u) begin
          cmd.op  = busWrite ? OP_STS_CLR : OP_RD_STS;
          cmd.idx = 8'(u);
        end
        if (addr == STS_BASE + USR_STEP * u + 4) begin
          cmd.op  = busWrite ? (LEGACY ? OP_EN_WR : OP_EN_SET) : OP_RD_EN;
          cmd.idx = 8'(u);
        end
        if (!LEGACY && addr == STS_BASE + USR_STEP * u + 8) begin
          cmd.op  = busWrite ? OP_EN_CLR : OP_RD_EN;
          cmd.idx = 8'(u);
        end
      end
    end
  end

  logic [31:0] rdNext;
  always_comb begin
    rdNext = '0;
    case (cmd.op)
      OP_RD_REV: rdNext = REVISION;
      default: ;
    endcase
    for (int m = 0; m < NUM_QUEUES; m++) begin
      if (cmd.idx == 8'(m)) begin
        if (cmd.op == OP_POP && qCount[m] != '0) rdNext = qHead[m];
        if (cmd.op == OP_RD_FULL) rdNext = {31'b0, qFull[m]};
        if (cmd.op == OP_RD_CNT)  rdNext = 32'(qCount[m]);
      end
    end
    for (int u = 0; u < NUM_USERS; u++) begin
      if (cmd.idx == 8'(u)) begin
        if (cmd.op == OP_RD_STS) rdNext = 32'(stsAll[u]);
        if (cmd.op == OP_RD_EN)  rdNext = 32'(enAll[u]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     busRdata <= '0;
    else if (busSel && !busWrite)  busRdata <= rdNext;
  end
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int NUM_QUEUES = 4,
  parameter int NUM_USERS  = 3,
  parameter int DEPTH      = 4,
  parameter bit LEGACY     = 1'b0,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int EW = 2 * NUM_QUEUES
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  mbox_cmd_t                     cmd,
  input  logic [31:0]                   busWdata,
  output logic [NUM_QUEUES-1:0][CW-1:0] qCount,
  output logic [NUM_QUEUES-1:0]         qFull,
  output logic [NUM_QUEUES-1:0][31:0]   qHead,
  output logic [NUM_USERS-1:0][EW-1:0]  stsAll,
  output logic [NUM_USERS-1:0][EW-1:0]  enAll,
  output logic [NUM_USERS-1:0]          irqOut
);
  logic [EW-1:0] evVec;

  for (genvar m = 0; m < NUM_QUEUES; m++) begin : g_queue
    logic pushM, popM;
    assign pushM = (cmd.op == OP_PUSH) && (cmd.idx == 8'(m));
    assign popM  = (cmd.op == OP_POP)  && (cmd.idx == 8'(m));
    assign evVec[2*m]   = pushM && !qFull[m];
    assign evVec[2*m+1] = popM && qFull[m];

    mbox_queue #(.DEPTH(DEPTH), .DW(32)) u_queue (
      .clk   (clk),
      .rstN  (rstN),
      .push  (pushM),
      .pop   (popM),
      .wdata (busWdata),
      .count (qCount[m]),
      .full  (qFull[m]),
      .head  (qHead[m])
    );
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
    logic hitU;
    logic [EW-1:0] clrMask;
    assign hitU    = (cmd.idx == 8'(u));
    assign clrMask = (hitU && cmd.op == OP_STS_CLR) ? busWdata[EW-1:0] : '0;

    always_ff @(posedge clk) begin
      if (!rstN) stsAll[u] <= '0;
      else       stsAll[u] <= (stsAll[u] & ~clrMask) | evVec;
    end

    if (LEGACY) begin : g_plain_en
      always_ff @(posedge clk) begin
        if (!rstN)                            enAll[u] <= '0;
        else if (hitU && cmd.op == OP_EN_WR)  enAll[u] <= busWdata[EW-1:0];
      end
    end else begin : g_split_en
      always_ff @(posedge clk) begin
        if (!rstN)                             enAll[u] <= '0;
        else if (hitU && cmd.op == OP_EN_SET)  enAll[u] <= enAll[u] | busWdata[EW-1:0];
        else if (hitU && cmd.op == OP_EN_CLR)  enAll[u] <= enAll[u] & ~busWdata[EW-1:0];
      end
    end

    assign irqOut[u] = |(stsAll[u] & enAll[u]);
  end
endmodule

// File: rtl/mbox_unit.sv
module mbox_unit
  import mbox_pkg::*;
#(
  parameter int          NUM_QUEUES = 4,
  parameter int          NUM_USERS  = 3,
  parameter int          DEPTH      = 4,
  parameter int          ADDR_W     = 10,
  parameter bit          LEGACY     = 1'b0,
  parameter logic [31:0] REVISION   = 32'h0001_0200,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int EW = 2 * NUM_QUEUES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic [NUM_USERS-1:0] irqOut
);
  mbox_cmd_t                     cmd;
  logic [NUM_QUEUES-1:0][CW-1:0] qCount;
  logic [NUM_QUEUES-1:0]         qFull;
  logic [NUM_QUEUES-1:0][31:0]   qHead;
  logic [NUM_USERS-1:0][EW-1:0]  stsAll;
  logic [NUM_USERS-1:0][EW-1:0]  enAll;

  mbox_ctrl #(
    .NUM_QUEUES(NUM_QUEUES), .NUM_USERS(NUM_USERS), .DEPTH(DEPTH),
    .ADDR_W(ADDR_W), .LEGACY(LEGACY), .REVISION(REVISION)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .qCount(qCount), .qFull(qFull), .qHead(qHead),
    .stsAll(stsAll), .enAll(enAll), .cmd(cmd), .busRdata(busRdata)
  );

  mbox_datapath #(
    .NUM_QUEUES(NUM_QUEUES), .NUM_USERS(NUM_USERS), .DEPTH(DEPTH),
    .LEGACY(LEGACY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .busWdata(busWdata),
    .qCount(qCount), .qFull(qFull), .qHead(qHead),
    .stsAll(stsAll), .enAll(enAll), .irqOut(irqOut)
  );
endmodule

// File: rtl/mbox_unit_chk.sv
module mbox_unit_chk
  import mbox_pkg::*;
#(
  parameter int NUM_QUEUES = 4,
  parameter int NUM_USERS  = 3,
  parameter int DEPTH      = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int EW = 2 * NUM_QUEUES
) (
  input logic                          clk,
  input logic                          rstN,
  input mbox_cmd_t                     cmd,
  input logic [EW-1:0]                 wdLow,
  input logic [NUM_QUEUES-1:0][CW-1:0] qCount,
  input logic [NUM_QUEUES-1:0]         qFull,
  input logic [NUM_USERS-1:0][EW-1:0]  stsAll
);
  for (genvar m = 0; m < NUM_QUEUES; m++) begin : g_q
    logic pushM, popM;
    assign pushM = (cmd.op == OP_PUSH) && (cmd.idx == 8'(m));
    assign popM  = (cmd.op == OP_POP)  && (cmd.idx == 8'(m));

    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
      qCount[m] <= CW'(DEPTH));
    a_r2_push_grows: assert property (@(posedge clk) disable iff (!rstN)
      (pushM && !qFull[m]) |=> (qCount[m] == $past(qCount[m]) + 1'b1));
    a_r3_full_drop: assert property (@(posedge clk) disable iff (!rstN)
      (pushM && qFull[m]) |=> $stable(qCount[m]));
    a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
      (popM && qCount[m] == '0) |=> ($stable(qCount[m]) && $stable(stsAll)));

    for (genvar u = 0; u < NUM_USERS; u++) begin : g_u
      a_r7_new_event: assert property (@(posedge clk) disable iff (!rstN)
        (pushM && !qFull[m]) |=> stsAll[u][2*m]);
      a_r8_notfull_event: assert property (@(posedge clk) disable iff (!rstN)
        (popM && qFull[m]) |=> stsAll[u][2*m+1]);
    end
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_w1c
    a_r9_w1c: assert property (@(posedge clk) disable iff (!rstN)
      (cmd.op == OP_STS_CLR && cmd.idx == 8'(u)) |=> ((stsAll[u] & $past(wdLow)) == '0));
  end
endmodule

bind mbox_unit mbox_unit_chk #(
  .NUM_QUEUES(NUM_QUEUES), .NUM_USERS(NUM_USERS), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rstN(rstN), .cmd(cmd), .wdLow(busWdata[2*NUM_QUEUES-1:0]),
  .qCount(qCount), .qFull(qFull), .stsAll(stsAll)
);

// File: tb/mbox_unit_bench.sv
module mbox_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4;
  localparam int NU = 3;
  localparam int DEPTH = 4;
  localparam int EW = 2 * NQ;
  localparam logic [31:0] REV = 32'h0001_0200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        sel [2];
  logic        wr  [2];
  logic [9:0]  addr[2];
  logic [31:0] wd  [2];
  logic [31:0] rd  [2];
  logic [NU-1:0] irq[2];

  mbox_unit #(.LEGACY(1'b0)) u_mbox_unit (
    .clk(clk), .rstN(rstN), .busSel(sel[0]), .busWrite(wr[0]),
    .busAddr(addr[0]), .busWdata(wd[0]), .busRdata(rd[0]), .irqOut(irq[0]));

  mbox_unit #(.LEGACY(1'b1)) u_mbox_unit_legacy (
    .clk(clk), .rstN(rstN), .busSel(sel[1]), .busWrite(wr[1]),
    .busAddr(addr[1]), .busWdata(wd[1]), .busRdata(rd[1]), .irqOut(irq[1]));

  int checks = 0;
  int failures = 0;
  string curReq = "R13";

  // behavioural reference
  logic [31:0]   mq[2][NQ][$];
  logic [31:0]   mRd[2];
  logic [EW-1:0] mSts[2][NU];
  logic [EW-1:0] mEn[2][NU];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin
        for (int m = 0; m < NQ; m++) mq[i][m].delete();
        mRd[i] = 0;
        for (int u = 0; u < NU; u++) begin mSts[i][u] = 0; mEn[i][u] = 0; end
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (sel[i]) begin
          logic [EW-1:0] ev;
          int a;
          ev = 0;
          a = int'(addr[i]);
          if (!wr[i]) mRd[i] = 0;
          if (!wr[i] && a == 0) mRd[i] = REV;
          for (int m = 0; m < NQ; m++) begin
            if (a == 'h40 + 4 * m) begin
              if (wr[i]) begin
                if (mq[i][m].size() < DEPTH) begin
                  mq[i][m].push_back(wd[i]);
                  ev[2*m] = 1'b1;
                end
              end else if (mq[i][m].size() > 0) begin
                if (mq[i][m].size() == DEPTH) ev[2*m+1] = 1'b1;
                mRd[i] = mq[i][m].pop_front();
              end
            end
            if (!wr[i] && a == 'h80 + 4 * m) mRd[i] = (mq[i][m].size() == DEPTH) ? 1 : 0;
            if (!wr[i] && a == 'hC0 + 4 * m) mRd[i] = mq[i][m].size();
          end
          for (int u = 0; u < NU; u++) begin
            int sa;
            sa = (i == 1) ? ('h100 + 8 * u) : ('h104 + 16 * u);
            if (a == sa) begin
              if (wr[i]) mSts[i][u] = mSts[i][u] & ~wd[i][EW-1:0];
              else       mRd[i] = 32'(mSts[i][u]);
            end
            if (a == sa + 4) begin
              if (!wr[i])     mRd[i] = 32'(mEn[i][u]);
              else if (i == 1) mEn[i][u] = wd[i][EW-1:0];
              else            mEn[i][u] = mEn[i][u] | wd[i][EW-1:0];
            end
            if (i == 0 && a == sa + 8) begin
              if (!wr[i]) mRd[i] = 32'(mEn[i][u]);
              else        mEn[i][u] = mEn[i][u] & ~wd[i][EW-1:0];
            end
          end
          for (int u = 0; u < NU; u++) mSts[i][u] = mSts[i][u] | ev;
        end
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (rstN) begin
      for (int i = 0; i < 2; i++) begin
        logic [NU-1:0] e;
        for (int u = 0; u < NU; u++) e[u] = |(mSts[i][u] & mEn[i][u]);
        check(curReq, rd[i], mRd[i]);
        check("R12", 32'(irq[i]), 32'(e));
      end
    end
  end

  task automatic busWr(int i, int a, logic [31:0] d);
    @(negedge clk);
    sel[i] = 1'b1; wr[i] = 1'b1; addr[i] = 10'(a); wd[i] = d;
    @(negedge clk);
    sel[i] = 1'b0; wr[i] = 1'b0;
  endtask

  task automatic busRd(int i, int a, logic [31:0] exp, string req);
    @(negedge clk);
    sel[i] = 1'b1; wr[i] = 1'b0; addr[i] = 10'(a);
    @(negedge clk);
    check(req, rd[i], exp);
    sel[i] = 1'b0;
  endtask

  task automatic irqChk(int i, logic [NU-1:0] exp, string req);
    check(req, 32'(irq[i]), 32'(exp));
  endtask

  bit done = 1'b0;

  initial begin
    for (int i = 0; i < 2; i++) begin
      sel[i] = 0; wr[i] = 0; addr[i] = 0; wd[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R13 reset state
    irqChk(0, 3'b000, "R13");
    busRd(0, 'h0C0, 0, "R13");
    busRd(0, 'h104, 0, "R13");
    // R1 revision
    curReq = "R1";
    busRd(0, 'h000, REV, "R1");
    busWr(0, 'h000, 32'hFFFF_FFFF);
    busRd(0, 'h000, REV, "R1");
    // R10 split enables
    curReq = "R10";
    busWr(0, 'h108, 32'h01);
    busWr(0, 'h118, 32'h02);
    busRd(0, 'h108, 32'h01, "R10");
    busRd(0, 'h10C, 32'h01, "R10");
    busRd(0, 'h118, 32'h02, "R10");
    // R2 R6 R7 pushes
    curReq = "R2";
    busWr(0, 'h040, 32'h11);
    busWr(0, 'h040, 32'h22);
    busRd(0, 'h0C0, 2, "R6");
    busRd(0, 'h104, 32'h01, "R7");
    busRd(0, 'h124, 32'h01, "R7");
    irqChk(0, 3'b001, "R12");
    // R5 R3 fill and overflow
    busWr(0, 'h040, 32'h33);
    busWr(0, 'h040, 32'h44);
    busRd(0, 'h080, 1, "R5");
    curReq = "R3";
    busWr(0, 'h040, 32'h55);
    busRd(0, 'h0C0, DEPTH, "R3");
    // R8 pop from full
    busRd(0, 'h040, 32'h11, "R2");
    irqChk(0, 3'b011, "R8");
    busRd(0, 'h114, 32'h03, "R8");
    busRd(0, 'h080, 0, "R5");
    busRd(0, 'h040, 32'h22, "R2");
    busRd(0, 'h040, 32'h33, "R2");
    busRd(0, 'h040, 32'h44, "R3");
    // R4 empty pop
    curReq = "R4";
    busRd(0, 'h040, 0, "R4");
    busRd(0, 'h0C0, 0, "R4");
    busRd(0, 'h104, 32'h03, "R4");
    // R9 write-one-to-clear
    curReq = "R9";
    busWr(0, 'h104, 32'h02);
    busRd(0, 'h104, 32'h01, "R9");
    busWr(0, 'h104, 32'h01);
    busRd(0, 'h104, 32'h00, "R9");
    irqChk(0, 3'b010, "R12");
    // R7 on another queue
    curReq = "R7";
    busWr(0, 'h04C, 32'h99);
    busRd(0, 'h124, 32'h43, "R7");
    busRd(0, 'h0CC, 1, "R6");
    // R10 enable clear
    curReq = "R10";
    busWr(0, 'h10C, 32'h01);
    busRd(0, 'h108, 32'h00, "R10");
    irqChk(0, 3'b010, "R12");
    // R11 legacy layout
    curReq = "R11";
    busWr(1, 'h104, 32'h05);
    busRd(1, 'h104, 32'h05, "R11");
    busWr(1, 'h104, 32'h01);
    busRd(1, 'h104, 32'h01, "R11");
    busRd(1, 'h10C, 32'h00, "R11");
    busWr(1, 'h040, 32'hAB);
    irqChk(1, 3'b001, "R12");
    busRd(1, 'h100, 32'h01, "R11");
    busWr(1, 'h100, 32'h01);
    busRd(1, 'h100, 32'h00, "R9");
    irqChk(1, 3'b000, "R12");
    busWr(1, 'h10C, 32'h01);
    busRd(1, 'h10C, 32'h01, "R11");
    busRd(1, 'h040, 32'hAB, "R2");
    irqChk(1, 3'b010, "R11");
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule